// File: doc/BRIEF.md
# Modulo Timer with Overflow Interrupt

This block is a 16-bit up-counting timer on a simple 32-bit register bus. Software picks a prescaler exponent and a clock source in a control word. While the source is the system clock, the counter steps once per prescaled tick. It starts from a programmable start value and counts up to a programmable end value. On the tick after it reaches the end value, it returns to the start value and latches an overflow flag. The interrupt line is that flag gated by an enable bit.

The end value and the start value are double buffered. A bus write only fills a shadow copy. The shadow copies move into the working registers while the clock-source field reads as stopped, so a reprogrammed period never tears a count that is in progress. Any write to the counter address forces the counter to the working start value. This gives software a clean restart point. A typical one-shot or periodic use is: stop the counter, load the end value, write the counter, then start with the interrupt enabled.

Top module: `mod_timer`

## Requirements
- R1: After reset, the control word (0x00), the counter (0x04) and the start value (0x4C) read 0, the end value (0x08) reads 0x0000FFFF, and irq is low.
- R2: On each tick the counter adds one. On the tick after it equals the working end value, it loads the working start value instead. A period is therefore end - start + 1 ticks.
- R3: The overflow flag, control bit 7, becomes 1 on exactly the tick that takes the counter from the end value back to the start value.
- R4: Control bits [2:0] hold the exponent P, and a tick occurs every 2^P clocks only while control bits [4:3] equal 1. With any other value in bits [4:3], the counter holds its value.
- R5: A control write with bits [4:3] = 0 clears the prescale divider. After the counter restarts, its first tick comes a full 2^P clocks after the start write.
- R6: A write of any data to the counter address sets the counter to the working start value on the next clock. This load takes priority over a tick in the same cycle.
- R7: Writes to 0x08 and 0x4C go to shadow copies. A shadow copy moves into the working register only on clocks where bits [4:3] are 0. Reads of 0x08 and 0x4C return the working values, so a write made while running leaves the period unchanged.
- R8: A control write with bit 7 = 0 clears the flag only if a control read has returned the flag as 1 since the previous control write. Writing bit 7 = 1 has no effect on the flag.
- R9: When a valid clear and a new overflow fall on the same clock, the flag stays set.
- R10: irq equals the flag ANDed with control bit 6. It stays high until the flag clears.
- R11: The counter and end value are 16 bits wide and read back zero-extended to 32 bits. The control word reads back as {flag, enable, 0, source[1:0], P[2:0]}, and any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Byte address of the register accessed |
| wrEn | input | 1 | Write strobe for one clock |
| rdEn | input | 1 | Read strobe for one clock (arms the flag clear) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr (combinational) |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench runs the counter through full periods at two prescaler settings. A design that set the flag on reaching the end value, rather than on leaving it, would show the flag one tick early. A design whose divider kept its old phase across a stop would step one clock early after a restart. The bench reprograms the end value while the counter runs and expects the old period to continue. A design that skipped the shadow copy would change the period at once. It also times a flag clear onto the very clock of a wrap, where a clear-wins design would lose an interrupt. It then checks that an unread flag, or a written 1, leaves the flag set. A design that did not require the read first would clear a flag that software never saw.

// File: rtl/mod_timer_pkg.sv
package mod_timer_pkg;

  // Register byte offsets (software-visible map)
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_COUNT = 'h04;
  localparam int OFS_END   = 'h08;
  localparam int OFS_START = 'h4C;

  // Control word field positions
  localparam int CTRL_PS_LSB  = 0;
  localparam int CTRL_SRC_LSB = 3;
  localparam int CTRL_IE_BIT  = 6;
  localparam int CTRL_OVF_BIT = 7;

  // Clock-source codes
  localparam logic [1:0] SRC_OFF = 2'd0;
  localparam logic [1:0] SRC_SYS = 2'd1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_COUNT,
    SEL_END,
    SEL_START
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;       // counter clock is the system clock
    logic cntLoad;   // force counter to working start value
    logic divClear;  // restart prescale divider
    logic bufCopy;   // shadow copies may move to working registers
  } dpCtl_t;

endpackage

// File: rtl/mod_timer_dp.sv
module mod_timer_dp
  import mod_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [PS_W-1:0]  psExp,
  input  logic [CNT_W-1:0] endBuf,
  input  logic [CNT_W-1:0] startBuf,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] endActive,
  output logic [CNT_W-1:0] startActive,
  output logic             wrapEvt
);

  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divLimit;
  logic             tick;
  logic             atEnd;

  // Terminal divider value is 2^P - 1
  assign divLimit = DIV_W'({DIV_W{1'b1}} >> (PS_W'(DIV_W) - psExp));
  assign tick     = ctl.run && (divQ >= divLimit);
  assign atEnd    = (cntVal == endActive);
  assign wrapEvt  = tick && atEnd && !ctl.cntLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
    end else if (ctl.divClear) begin
      divQ <= '0;
    end else if (ctl.run) begin
      divQ <= tick ? '0 : divQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (ctl.cntLoad) begin
      cntVal <= startActive;
    end else if (tick) begin
      cntVal <= atEnd ? startActive : cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endActive   <= '1;
      startActive <= '0;
    end else if (ctl.bufCopy) begin
      endActive   <= endBuf;
      startActive <= startBuf;
    end
  end

endmodule

// File: rtl/mod_timer_ctrl.sv
module mod_timer_ctrl
  import mod_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrapEvt,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  endActive,
  input  logic [CNT_W-1:0]  startActive,
  output dpCtl_t            ctl,
  output logic [PS_W-1:0]   psExp,
  output logic [CNT_W-1:0]  endBuf,
  output logic [CNT_W-1:0]  startBuf,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  regSel_e    sel;
  logic [1:0] srcQ;
  logic       ieQ;
  logic       flagQ;
  logic       armedQ;
  logic       ctrlWr;
  logic       clearReq;
  logic       unusedHi;

  always_comb begin
    sel = SEL_NONE;
    if (regAddr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    if (regAddr == ADDR_W'(OFS_COUNT)) sel = SEL_COUNT;
    if (regAddr == ADDR_W'(OFS_END))   sel = SEL_END;
    if (regAddr == ADDR_W'(OFS_START)) sel = SEL_START;
  end

  assign ctrlWr   = wrEn && (sel == SEL_CTRL);
  assign clearReq = ctrlWr && !wrData[CTRL_OVF_BIT] && armedQ;
  assign unusedHi = ^wrData[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psExp <= '0;
      srcQ  <= SRC_OFF;
      ieQ   <= 1'b0;
    end else if (ctrlWr) begin
      psExp <= wrData[CTRL_PS_LSB +: PS_W];
      srcQ  <= wrData[CTRL_SRC_LSB +: 2];
      ieQ   <= wrData[CTRL_IE_BIT];
    end
  end

  // New overflow beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (wrapEvt) begin
      flagQ <= 1'b1;
    end else if (clearReq) begin
      flagQ <= 1'b0;
    end
  end

  // A clear needs a read of the flag as 1 since the last control write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (ctrlWr) begin
      armedQ <= 1'b0;
    end else if (rdEn && (sel == SEL_CTRL) && flagQ) begin
      armedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endBuf   <= '1;
      startBuf <= '0;
    end else if (wrEn) begin
      if (sel == SEL_END)   endBuf   <= wrData[CNT_W-1:0];
      if (sel == SEL_START) startBuf <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.run      = (srcQ == SRC_SYS);
    ctl.cntLoad  = wrEn && (sel == SEL_COUNT);
    ctl.divClear = ctrlWr && (wrData[CTRL_SRC_LSB +: 2] == SRC_OFF);
    ctl.bufCopy  = (srcQ == SRC_OFF);
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:  rdData = DATA_W'({flagQ, ieQ, 1'b0, srcQ, psExp});
      SEL_COUNT: rdData = DATA_W'(cntVal);
      SEL_END:   rdData = DATA_W'(endActive);
      SEL_START: rdData = DATA_W'(startActive);
      default:   rdData = '0;
    endcase
  end

  assign irq = flagQ && ieQ;

endmodule

// File: rtl/mod_timer.sv
module mod_timer
  import mod_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  dpCtl_t           ctl;
  logic [PS_W-1:0]  psExp;
  logic [CNT_W-1:0] endBuf;
  logic [CNT_W-1:0] startBuf;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] endActive;
  logic [CNT_W-1:0] startActive;
  logic             wrapEvt;

  mod_timer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .wrapEvt(wrapEvt), .cntVal(cntVal),
    .endActive(endActive), .startActive(startActive), .ctl(ctl),
    .psExp(psExp), .endBuf(endBuf), .startBuf(startBuf),
    .rdData(rdData), .irq(irq)
  );

  mod_timer_dp #(
    .CNT_W(CNT_W), .PS_W(PS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .psExp(psExp), .endBuf(endBuf),
    .startBuf(startBuf), .cntVal(cntVal), .endActive(endActive),
    .startActive(startActive), .wrapEvt(wrapEvt)
  );

endmodule

// File: rtl/mod_timer_chk.sv
module mod_timer_chk
  import mod_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              irq,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  endActive,
  input logic [CNT_W-1:0]  startActive,
  input logic              wrapEvt,
  input dpCtl_t            ctl
);

  a_r2_reload_start: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> cntVal == $past(startActive));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.cntLoad && !wrapEvt) |=>
      (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1));

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.cntLoad) |=> $stable(cntVal));

  a_r6_load_start: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntLoad |=> cntVal == $past(startActive));

  a_r7_working_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.bufCopy |=> ($stable(endActive) && $stable(startActive)));

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && regAddr == ADDR_W'(OFS_CTRL))) |=> irq);

endmodule

bind mod_timer mod_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .irq(irq),
  .cntVal(cntVal), .endActive(endActive), .startActive(startActive),
  .wrapEvt(wrapEvt), .ctl(ctl)
);

// File: tb/mod_timer_bench.sv
module mod_timer_bench;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        expIrq;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,   8'h08, 32'd3,      32'd0,      1'b0}, // end=3 (stopped)
    '{OP_WR,   8'h4C, 32'd0,      32'd0,      1'b0},
    '{OP_WR,   8'h04, 32'd0,      32'd0,      1'b0}, // R6 load start
    '{OP_WR,   8'h00, 32'h48,     32'd0,      1'b0}, // run, ie, P=0
    '{OP_RD,   8'h04, 32'd0,      32'd0,      1'b0}, // R2
    '{OP_RD,   8'h04, 32'd0,      32'd1,      1'b0}, // R2
    '{OP_RD,   8'h04, 32'd0,      32'd2,      1'b0}, // R2
    '{OP_RD,   8'h04, 32'd0,      32'd3,      1'b0}, // R3 no flag at end yet
    '{OP_RD,   8'h00, 32'd0,      32'hC8,     1'b1}, // R3 R10 flag after wrap
    '{OP_WR,   8'h00, 32'hC8,     32'd0,      1'b0}, // R8 write 1
    '{OP_RD,   8'h00, 32'd0,      32'hC8,     1'b1}, // R8 still set
    '{OP_WR,   8'h00, 32'h48,     32'd0,      1'b0}, // R9 clear on wrap clock
    '{OP_RD,   8'h04, 32'd0,      32'd0,      1'b1}, // R9 flag kept
    '{OP_RD,   8'h00, 32'd0,      32'hC8,     1'b1},
    '{OP_WR,   8'h00, 32'h48,     32'd0,      1'b0}, // R8 valid clear
    '{OP_RD,   8'h00, 32'd0,      32'h48,     1'b0}, // R8 cleared
    '{OP_WR,   8'h00, 32'h08,     32'd0,      1'b0}, // R8 unread clear, ie=0
    '{OP_RD,   8'h00, 32'd0,      32'h88,     1'b0}, // R8 R10 gated
    '{OP_WR,   8'h00, 32'h00,     32'd0,      1'b0}, // stop, clears flag
    '{OP_RD,   8'h04, 32'd0,      32'd3,      1'b0}, // R4 hold
    '{OP_WR,   8'h08, 32'd5,      32'd0,      1'b0},
    '{OP_WR,   8'h4C, 32'd2,      32'd0,      1'b0},
    '{OP_IDLE, 8'h00, 32'd1,      32'd0,      1'b0},
    '{OP_WR,   8'h04, 32'hFFFF,   32'd0,      1'b0}, // R6 any data
    '{OP_RD,   8'h04, 32'd0,      32'd2,      1'b0}, // R6
    '{OP_WR,   8'h00, 32'h49,     32'd0,      1'b0}, // run P=1
    '{OP_RD,   8'h04, 32'd0,      32'd2,      1'b0}, // R5 full period
    '{OP_RD,   8'h04, 32'd0,      32'd2,      1'b0}, // R5
    '{OP_RD,   8'h04, 32'd0,      32'd3,      1'b0}, // R4
    '{OP_RD,   8'h04, 32'd0,      32'd3,      1'b0}, // R4
    '{OP_IDLE, 8'h00, 32'd2,      32'd0,      1'b0},
    '{OP_RD,   8'h04, 32'd0,      32'd5,      1'b0}, // R4
    '{OP_RD,   8'h04, 32'd0,      32'd5,      1'b0},
    '{OP_RD,   8'h00, 32'd0,      32'hC9,     1'b1}, // R2 R3 wrap to start
    '{OP_WR,   8'h08, 32'd9,      32'd0,      1'b0}, // R7 write while running
    '{OP_RD,   8'h04, 32'd0,      32'd3,      1'b1},
    '{OP_IDLE, 8'h00, 32'd2,      32'd0,      1'b0},
    '{OP_RD,   8'h04, 32'd0,      32'd4,      1'b1},
    '{OP_RD,   8'h04, 32'd0,      32'd5,      1'b1},
    '{OP_RD,   8'h04, 32'd0,      32'd5,      1'b1}, // R7 old end still used
    '{OP_RD,   8'h04, 32'd0,      32'd2,      1'b1}, // R7
    '{OP_RD,   8'h08, 32'd0,      32'd5,      1'b1}, // R7 working end
    '{OP_WR,   8'h04, 32'd0,      32'd0,      1'b1}, // R6 load while running
    '{OP_RD,   8'h04, 32'd0,      32'd2,      1'b1}, // R6
    '{OP_RD,   8'h04, 32'd0,      32'd3,      1'b1},
    '{OP_RD,   8'h4C, 32'd0,      32'd2,      1'b1}, // R11
    '{OP_RD,   8'h10, 32'd0,      32'd0,      1'b1}  // R11 unmapped
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mod_timer u_mod_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual irq/data %h, expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic doRead(input string req, input logic [7:0] a,
                        input logic [31:0] e, input logic ei);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1 check(req, {irq, rdData}, {ei, e});
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running, expected finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    doRead("R1", 8'h00, 32'h0, 1'b0);
    doRead("R1", 8'h04, 32'h0, 1'b0);
    doRead("R1", 8'h08, 32'h0000FFFF, 1'b0);
    doRead("R1", 8'h4C, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR: doWrite(VECS[i].addr, VECS[i].data);
        OP_RD: doRead($sformatf("vector %0d", i), VECS[i].addr,
                      VECS[i].exp, VECS[i].expIrq);
        default: begin
          @(negedge clk);
          repeat (VECS[i].data) @(posedge clk);
        end
      endcase
    end

    // R4: source code 2 does not count; valid clear also drops irq (R10)
    doWrite(8'h00, 32'h10);
    @(negedge clk);
    held = rdData;
    regAddr = 8'h04;
    #1 held = rdData;
    repeat (5) @(posedge clk);
    doRead("R4 source 2 holds", 8'h04, held, 1'b0);
    doRead("R10 after clear", 8'h00, 32'h10, 1'b0);

    // R1 reset in the middle of activity
    doWrite(8'h00, 32'h48);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doRead("R1 mid-run reset", 8'h00, 32'h0, 1'b0);
    doRead("R1 mid-run reset", 8'h04, 32'h0, 1'b0);
    doRead("R1 mid-run reset", 8'h08, 32'h0000FFFF, 1'b0);

    done = 1'b1;
    finishRun();
  end

endmodule